// File: doc/BRIEF.md
# Tagged Circular Register Stack

This block holds eight wide floating-point entries and presents them as a stack. A three-bit top pointer moves around the eight physical slots. Software-visible indices are always relative to the current top. A push moves the pointer down by one slot and fills the slot it lands on. A pop frees the top slot and moves the pointer up by one. A relative write replaces the value held at a given stack depth. The block accepts one command per cycle.

Each physical slot carries a two-bit content tag. The tag is computed from the value when the value is written. The eight tags are packed into a 16-bit tag word, ordered by physical slot number.

Overflow and underflow are reported as a stack fault together with an invalid-operation flag. The C1 condition bit tells the two apart. Two combinational read ports return the value at any relative depth, plus a flag that is set when that slot is empty. An arithmetic unit can use this flag to raise its own underflow.

Top module: `tagstack_top`

## Requirements
- R1: When `rst` or `init` is sampled high, the next cycle shows `top_ptr` = 0, `tag_word` = 16'hFFFF, and `fault_sf`, `fault_inv` and `cond_c1` all low.
- R2: A push (`cmd` = 2'b01) sets `top_ptr` to (top − 1) mod 8 and stores `cmd_data` in that physical slot. After init, the first push lands in slot 7 and the second in slot 6.
- R3: The tag for slot p sits in `tag_word[2p+1:2p]`. The codes are: 00 = valid non-zero, 01 = zero (exponent 0 and significand 0), 10 = special (exponent all ones, or exponent 0 with a non-zero significand), 11 = empty. After init, pushing a normal non-zero value gives 16'h3FFF, and then pushing zero gives 16'h1FFF.
- R4: A pop (`cmd` = 2'b10) tags the current top slot empty and sets `top_ptr` to (top + 1) mod 8.
- R5: Relative index i addresses physical slot (top + i) mod 8, on both read ports and for the relative write. Index 0 is always the top.
- R6: A push whose target slot is not empty still moves `top_ptr`. It does not store `cmd_data`. Instead the slot receives the indefinite NaN (sign 1, exponent all ones, significand C000_0000_0000_0000h) and is tagged 10. `fault_sf`, `fault_inv` and `cond_c1` all go to 1.
- R7: A pop of an empty top slot sets `fault_sf` and `fault_inv` to 1 and clears `cond_c1` to 0. The top pointer still advances as in R4.
- R8: A relative write (`cmd` = 2'b11) stores `cmd_data` at index `cmd_idx` and re-tags that slot per R3. It leaves `top_ptr` unchanged and raises no fault.
- R9: `rd_empty_a` and `rd_empty_b` are high exactly when the slot addressed by their port's relative index is tagged empty.
- R10: `fault_sf` and `fault_inv` are high only in the cycle after a faulting command. A non-faulting push, pop or write clears `cond_c1`. An idle cycle (`cmd` = 2'b00) holds `cond_c1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Synchronous initialise; empties the stack |
| cmd | input | 2 | 00 idle, 01 push, 10 pop, 11 relative write |
| cmd_idx | input | 3 | Relative index for the write command |
| cmd_data | input | 80 | Value for push or write |
| rd_idx_a | input | 3 | Relative index, read port A |
| rd_idx_b | input | 3 | Relative index, read port B |
| rd_data_a | output | 80 | Value at read port A |
| rd_data_b | output | 80 | Value at read port B |
| rd_empty_a | output | 1 | Slot at port A is empty |
| rd_empty_b | output | 1 | Slot at port B is empty |
| top_ptr | output | 3 | Physical slot number of the top |
| tag_word | output | 16 | Packed per-slot tags |
| fault_sf | output | 1 | Stack fault for the previous command |
| fault_inv | output | 1 | Invalid operation for the previous command |
| cond_c1 | output | 1 | Condition bit C1 |

## Verification
The hardest case to reach is overflow, because it needs all eight slots occupied. The stimulus reaches it with eight clean pushes and then a ninth push. The bench then checks that the wrapped slot holds the indefinite NaN while the slot one step below still holds its old value. Underflow is reached by draining the stack completely and then popping once more. The pointer wrap in both directions is observed through `top_ptr` and the relative read ports.

// File: rtl/tstk_pkg.sv
package tstk_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'b00,
    CMD_PUSH  = 2'b01,
    CMD_POP   = 2'b10,
    CMD_WRITE = 2'b11
  } stk_cmd_e;

  typedef enum logic [1:0] {
    TAG_VALID   = 2'b00,
    TAG_ZERO    = 2'b01,
    TAG_SPECIAL = 2'b10,
    TAG_EMPTY   = 2'b11
  } stk_tag_e;
endpackage

// File: rtl/tstk_classify.sv
module tstk_classify #(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64,
  localparam int VAL_W = 1 + EXP_W + SIG_W
) (
  input  logic [VAL_W-1:0]  val,
  output tstk_pkg::stk_tag_e tag
);
  import tstk_pkg::*;

  logic [EXP_W-1:0] exp_f;
  logic [SIG_W-1:0] sig_f;

  assign exp_f = val[VAL_W-2 -: EXP_W];
  assign sig_f = val[SIG_W-1:0];

  always_comb begin
    if (&exp_f)              tag = TAG_SPECIAL;
    else if (exp_f == '0)    tag = (sig_f == '0) ? TAG_ZERO : TAG_SPECIAL;
    else                     tag = TAG_VALID;
  end
endmodule

// File: rtl/tstk_topptr.sv
module tstk_topptr #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             dec,
  input  logic             inc,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] ptr_nx;

  always_comb begin
    ptr_nx = ptr;
    if (dec)      ptr_nx = ptr - PTR_W'(1);
    else if (inc) ptr_nx = ptr + PTR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (clr) ptr <= '0;
    else     ptr <= ptr_nx;
  end
endmodule

// File: rtl/tstk_store.sv
module tstk_store #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 80,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [AW-1:0]             waddr,
  input  logic [WIDTH-1:0]          wdata,
  input  logic [NRD-1:0][AW-1:0]    raddr,
  output logic [NRD-1:0][WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata[r] = mem[raddr[r]];
  end
endmodule

// File: rtl/tagstack_top.sv
module tagstack_top #(
  parameter int DEPTH = 8,
  parameter int EXP_W = 15,
  parameter int SIG_W = 64,
  localparam int VAL_W = 1 + EXP_W + SIG_W,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int TW_W  = 2 * DEPTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic [1:0]       cmd,
  input  logic [PTR_W-1:0] cmd_idx,
  input  logic [VAL_W-1:0] cmd_data,
  input  logic [PTR_W-1:0] rd_idx_a,
  input  logic [PTR_W-1:0] rd_idx_b,
  output logic [VAL_W-1:0] rd_data_a,
  output logic [VAL_W-1:0] rd_data_b,
  output logic             rd_empty_a,
  output logic             rd_empty_b,
  output logic [PTR_W-1:0] top_ptr,
  output logic [TW_W-1:0]  tag_word,
  output logic             fault_sf,
  output logic             fault_inv,
  output logic             cond_c1
);
  import tstk_pkg::*;

  localparam logic [VAL_W-1:0] INDEF_NAN =
    {1'b1, {EXP_W{1'b1}}, 2'b11, {(SIG_W-2){1'b0}}};

  stk_cmd_e   op;
  stk_tag_e   tag_q [DEPTH];
  stk_tag_e   wr_tag;
  logic       clr, is_push, is_pop, is_wr;
  logic       push_ok, pop_ok, push_ovf, pop_unf;
  logic [PTR_W-1:0] push_slot, wr_slot, waddr;
  logic [VAL_W-1:0] wdata;
  logic             we;
  logic [1:0][PTR_W-1:0] rd_slot;
  logic [1:0][VAL_W-1:0] rd_val;

  assign op      = stk_cmd_e'(cmd);
  assign clr     = rst | init;
  assign is_push = (op == CMD_PUSH);
  assign is_pop  = (op == CMD_POP);
  assign is_wr   = (op == CMD_WRITE);

  assign push_slot = top_ptr - PTR_W'(1);
  assign wr_slot   = top_ptr + cmd_idx;
  assign push_ok   = (tag_q[push_slot] == TAG_EMPTY);
  assign pop_ok    = (tag_q[top_ptr] != TAG_EMPTY);
  assign push_ovf  = is_push & ~push_ok;
  assign pop_unf   = is_pop & ~pop_ok;

  assign we    = ~clr & (is_push | is_wr);
  assign waddr = is_push ? push_slot : wr_slot;
  assign wdata = push_ovf ? INDEF_NAN : cmd_data;

  tstk_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_cls (
    .val (wdata),
    .tag (wr_tag)
  );

  tstk_topptr #(.DEPTH(DEPTH)) u_ptr (
    .clk (clk),
    .clr (clr),
    .dec (is_push),
    .inc (is_pop),
    .ptr (top_ptr)
  );

  assign rd_slot[0] = top_ptr + rd_idx_a;
  assign rd_slot[1] = top_ptr + rd_idx_b;

  tstk_store #(.DEPTH(DEPTH), .WIDTH(VAL_W), .NRD(2)) u_mem (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (rd_slot),
    .rdata (rd_val)
  );

  assign rd_data_a  = rd_val[0];
  assign rd_data_b  = rd_val[1];
  assign rd_empty_a = (tag_q[rd_slot[0]] == TAG_EMPTY);
  assign rd_empty_b = (tag_q[rd_slot[1]] == TAG_EMPTY);

  for (genvar s = 0; s < DEPTH; s++) begin : g_tag
    always_ff @(posedge clk) begin
      if (clr)
        tag_q[s] <= TAG_EMPTY;
      else if (is_push && push_slot == PTR_W'(s))
        tag_q[s] <= wr_tag;
      else if (is_wr && wr_slot == PTR_W'(s))
        tag_q[s] <= wr_tag;
      else if (is_pop && top_ptr == PTR_W'(s))
        tag_q[s] <= TAG_EMPTY;
    end
    assign tag_word[2*s +: 2] = tag_q[s];
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      fault_sf  <= 1'b0;
      fault_inv <= 1'b0;
      cond_c1   <= 1'b0;
    end else begin
      fault_sf  <= push_ovf | pop_unf;
      fault_inv <= push_ovf | pop_unf;
      if (op != CMD_IDLE) cond_c1 <= push_ovf;
    end
  end
endmodule

// File: rtl/tstk_checker.sv
module tstk_checker #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int TW_W  = 2 * DEPTH
) (
  input logic             clk,
  input logic             rst,
  input logic             init,
  input logic [1:0]       cmd,
  input logic [PTR_W-1:0] rd_idx_a,
  input logic             rd_empty_a,
  input logic [PTR_W-1:0] top_ptr,
  input logic [TW_W-1:0]  tag_word,
  input logic             fault_sf,
  input logic             fault_inv,
  input logic             cond_c1
);
  logic [PTR_W-1:0] top_q, below, rd_slot;
  logic             top_empty, below_empty;

  always_ff @(posedge clk) top_q <= top_ptr;

  assign below       = top_ptr - PTR_W'(1);
  assign rd_slot     = top_ptr + rd_idx_a;
  assign top_empty   = (tag_word[{top_ptr, 1'b0} +: 2] == 2'b11);
  assign below_empty = (tag_word[{below, 1'b0} +: 2] == 2'b11);

  assert_init_clears_R1: assert property (@(posedge clk) disable iff (rst)
    init |=> (top_ptr == '0) && (&tag_word) && !fault_sf && !fault_inv && !cond_c1);

  assert_push_moves_top_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'b01 && !init) |=> top_ptr == top_q - PTR_W'(1));

  assert_pop_frees_top_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'b10 && !init) |=>
      (top_ptr == top_q + PTR_W'(1)) && (tag_word[{top_q, 1'b0} +: 2] == 2'b11));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'b01 && !init && !below_empty) |=> fault_sf && fault_inv && cond_c1);

  assert_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'b10 && !init && top_empty) |=> fault_sf && fault_inv && !cond_c1);

  assert_write_keeps_top_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'b11 && !init) |=> (top_ptr == top_q) && !fault_sf);

  assert_empty_flag_R9: assert property (@(posedge clk) disable iff (rst)
    rd_empty_a == (tag_word[{rd_slot, 1'b0} +: 2] == 2'b11));

  assert_idle_holds_c1_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'b00 && !init) |=> !fault_sf && !fault_inv && $stable(cond_c1));
endmodule

bind tagstack_top tstk_checker #(.DEPTH(DEPTH)) u_tstk_checker (
  .clk        (clk),
  .rst        (rst),
  .init       (init),
  .cmd        (cmd),
  .rd_idx_a   (rd_idx_a),
  .rd_empty_a (rd_empty_a),
  .top_ptr    (top_ptr),
  .tag_word   (tag_word),
  .fault_sf   (fault_sf),
  .fault_inv  (fault_inv),
  .cond_c1    (cond_c1)
);

// File: tb/test_tagstack_top.sv
`timescale 1ns/1ps
module test_tagstack_top;
  localparam logic [79:0] V_ONE   = {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000};
  localparam logic [79:0] V_TWO   = {1'b0, 15'h4000, 64'h8000_0000_0000_0000};
  localparam logic [79:0] V_THREE = {1'b0, 15'h4000, 64'hC000_0000_0000_0000};
  localparam logic [79:0] V_ZERO  = 80'h0;
  localparam logic [79:0] V_INF   = {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000};
  localparam logic [79:0] V_DEN   = {1'b0, 15'h0000, 64'h0000_0000_0000_0001};
  localparam logic [79:0] V_INDEF = {1'b1, 15'h7FFF, 64'hC000_0000_0000_0000};

  typedef struct packed {
    logic [1:0]  c;
    logic [2:0]  i;
    logic [79:0] d;
    logic [2:0]  top;
    logic [15:0] tag;
    logic        sf;
    logic        inv;
    logic        c1;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'b01, 3'd0, V_ONE,  3'd7, 16'h3FFF, 1'b0, 1'b0, 1'b0},
    '{2'b01, 3'd0, V_ZERO, 3'd6, 16'h1FFF, 1'b0, 1'b0, 1'b0},
    '{2'b01, 3'd0, V_INF,  3'd5, 16'h1BFF, 1'b0, 1'b0, 1'b0},
    '{2'b01, 3'd0, V_DEN,  3'd4, 16'h1AFF, 1'b0, 1'b0, 1'b0},
    '{2'b11, 3'd1, V_ZERO, 3'd4, 16'h16FF, 1'b0, 1'b0, 1'b0},
    '{2'b10, 3'd0, V_ZERO, 3'd5, 16'h17FF, 1'b0, 1'b0, 1'b0},
    '{2'b10, 3'd0, V_ZERO, 3'd6, 16'h1FFF, 1'b0, 1'b0, 1'b0},
    '{2'b10, 3'd0, V_ZERO, 3'd7, 16'h3FFF, 1'b0, 1'b0, 1'b0},
    '{2'b10, 3'd0, V_ZERO, 3'd0, 16'hFFFF, 1'b0, 1'b0, 1'b0},
    '{2'b10, 3'd0, V_ZERO, 3'd1, 16'hFFFF, 1'b1, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst, init;
  logic [1:0]  cmd;
  logic [2:0]  cmd_idx, rd_idx_a, rd_idx_b;
  logic [79:0] cmd_data, rd_data_a, rd_data_b;
  logic        rd_empty_a, rd_empty_b, fault_sf, fault_inv, cond_c1;
  logic [2:0]  top_ptr;
  logic [15:0] tag_word;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tagstack_top i_tagstack_top (
    .clk(clk), .rst(rst), .init(init), .cmd(cmd), .cmd_idx(cmd_idx),
    .cmd_data(cmd_data), .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .rd_empty_a(rd_empty_a),
    .rd_empty_b(rd_empty_b), .top_ptr(top_ptr), .tag_word(tag_word),
    .fault_sf(fault_sf), .fault_inv(fault_inv), .cond_c1(cond_c1)
  );

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] c, input logic [2:0] i, input logic [79:0] d);
    @(negedge clk);
    cmd = c; cmd_idx = i; cmd_data = d;
    @(posedge clk);
    #1;
    cmd = 2'b00;
  endtask

  task automatic pulse_init();
    @(negedge clk);
    init = 1'b1;
    @(posedge clk);
    #1;
    init = 1'b0;
  endtask

  initial begin
    rst = 1'b1; init = 1'b0; cmd = 2'b00; cmd_idx = '0; cmd_data = '0;
    rd_idx_a = '0; rd_idx_b = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 top", 80'(top_ptr), 80'd0);
    check("R1 tag", 80'(tag_word), 80'hFFFF);
    check("R1 flags", 80'({fault_sf, fault_inv, cond_c1}), 80'd0);
    check("R9 empty after reset", 80'(rd_empty_a), 80'd1);
    @(negedge clk);
    rst = 1'b0;

    // Table walk: R2 R3 R4 R7 R8 R10
    for (int k = 0; k < NV; k++) begin
      issue(VEC[k].c, VEC[k].i, VEC[k].d);
      check($sformatf("R2/R4 top vec %0d", k), 80'(top_ptr), 80'(VEC[k].top));
      check($sformatf("R3 tag vec %0d", k), 80'(tag_word), 80'(VEC[k].tag));
      check($sformatf("R7/R10 flags vec %0d", k), 80'({fault_sf, fault_inv, cond_c1}),
            80'({VEC[k].sf, VEC[k].inv, VEC[k].c1}));
    end

    // R1 init clears mid-run
    issue(2'b01, 3'd0, V_ONE);
    pulse_init();
    check("R1 init top", 80'(top_ptr), 80'd0);
    check("R1 init tag", 80'(tag_word), 80'hFFFF);

    // R5 relative mapping on both ports
    issue(2'b01, 3'd0, V_ONE);
    issue(2'b01, 3'd0, V_TWO);
    issue(2'b01, 3'd0, V_THREE);
    check("R2 three pushes tag", 80'(tag_word), 80'h03FF);
    @(negedge clk);
    rd_idx_a = 3'd0; rd_idx_b = 3'd2;
    #1;
    check("R5 idx0 port A", rd_data_a, V_THREE);
    check("R5 idx2 port B", rd_data_b, V_ONE);
    check("R9 occupied A", 80'(rd_empty_a), 80'd0);
    rd_idx_a = 3'd1; rd_idx_b = 3'd3;
    #1;
    check("R5 idx1 port A", rd_data_a, V_TWO);
    check("R9 empty idx3 port B", 80'(rd_empty_b), 80'd1);

    // R8 relative write of zero at depth 2 (slot 7)
    issue(2'b11, 3'd2, V_ZERO);
    check("R8 top unchanged", 80'(top_ptr), 80'd5);
    check("R8 tag", 80'(tag_word), 80'h43FF);
    check("R8 no fault", 80'({fault_sf, fault_inv, cond_c1}), 80'd0);
    @(negedge clk);
    rd_idx_b = 3'd2;
    #1;
    check("R8 readback", rd_data_b, V_ZERO);

    // R6 overflow after eight clean pushes
    pulse_init();
    for (int k = 0; k < 8; k++) issue(2'b01, 3'd0, V_ONE);
    check("R6 full tag", 80'(tag_word), 80'h0000);
    check("R6 full top", 80'(top_ptr), 80'd0);
    issue(2'b01, 3'd0, V_TWO);
    check("R6 top moved", 80'(top_ptr), 80'd7);
    check("R6 tag special", 80'(tag_word), 80'h8000);
    check("R6 flags", 80'({fault_sf, fault_inv, cond_c1}), 80'b111);
    @(negedge clk);
    rd_idx_a = 3'd0; rd_idx_b = 3'd1;
    #1;
    check("R6 indefinite stored", rd_data_a, V_INDEF);
    check("R6 neighbour kept", rd_data_b, V_ONE);

    // R10 idle holds C1, clears faults; clean write clears C1
    issue(2'b00, 3'd0, V_ZERO);
    check("R10 idle flags", 80'({fault_sf, fault_inv, cond_c1}), 80'b001);
    issue(2'b11, 3'd0, V_ONE);
    check("R10 write clears c1", 80'({fault_sf, fault_inv, cond_c1}), 80'b000);
    check("R3 rewrite tag", 80'(tag_word), 80'h0000);

    // R1 reset pin mid-run
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    rst = 1'b0;
    check("R1 rst top", 80'(top_ptr), 80'd0);
    check("R1 rst tag", 80'(tag_word), 80'hFFFF);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule